// File: doc/BRIEF.md
# Memory Request Traffic Master

This block drives the user side of a memory controller that exposes a flat address space. Once the controller reports that calibration is finished and a start level is seen, it writes a fixed number of burst requests, then reads the same region back and checks every returned beat against the pattern it wrote. The command channel (enable, code, address) and the write-data channel (enable, data, last flag, byte mask) each handshake with their own ready input. The two channels run independently, so write data may go out before or after its command.

A returned read beat that differs from the expected pattern, or whose last flag is in the wrong place, sets a sticky error flag. The block then stops driving any request. When the whole pattern has come back correctly, a sticky done flag is raised.

Two small request generators turn user trigger pulses into one-cycle refresh and impedance-calibration requests. Each waits for its acknowledge before it will issue another.

Top module: `mem_traffic_master`

## Requirements
- R1: After reset `cmd_en`, `wr_en`, `ref_req`, `zq_req`, `done` and `error` are all low. While `calib_done` is low, neither `cmd_en` nor `wr_en` is ever high, even if `start` is high.
- R2: A command presented with `cmd_rdy` low stays presented in the next cycle, with the same `cmd_addr` and `cmd_code`, unless `error` is set.
- R3: The accepted commands are `NUM_REQ` writes (code 3'b000) followed by `NUM_REQ` reads (code 3'b001). The k-th request of each group uses address `BASE_ADDR + 8*BURST_BEATS*k`, so the address moves by 8 per data word.
- R4: Write beat j carries the pattern for word address `BASE_ADDR + 8*j`. In that pattern, 32-bit lane i (bits 32i+31..32i) equals `{i[7:0], 24'h5A5A5A}` XOR the zero-extended address. `wr_last` is high on beats `BURST_BEATS-1`, `2*BURST_BEATS-1`, and so on. `wr_mask` is all zero, where mask bit b covers data byte b and a 1 would suppress that byte. A beat refused by `wr_rdy` is held unchanged in the next cycle.
- R5: The write-data channel does not wait for command acceptance. With `cmd_rdy` held low, all write beats can still be accepted. No read command is issued before every write command and every write beat has been accepted.
- R6: A read beat whose data differs from the expected pattern, or whose `rd_last` does not match the burst position, sets `error`. From that cycle on, `cmd_en`, `wr_en` and `done` stay low.
- R7: `done` rises only after all write and read commands are accepted and all `NUM_REQ*BURST_BEATS` read beats have matched. Once high, it stays high.
- R8: A `ref_trig` (or `zq_trig`) pulse seen while `calib_done` is high produces a one-cycle `ref_req` (or `zq_req`) in the next cycle. Further triggers are ignored until the matching acknowledge has been seen. Triggers while `calib_done` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calib_done | input | 1 | Controller initialisation/calibration finished |
| start | input | 1 | Begin the write-then-read run |
| cmd_en | output | 1 | Command valid |
| cmd_code | output | 3 | 000 write, 001 read |
| cmd_addr | output | ADDR_W | Request address |
| cmd_rdy | input | 1 | Controller accepts the command this cycle |
| wr_en | output | 1 | Write beat valid |
| wr_data | output | DATA_W | Write beat data |
| wr_last | output | 1 | Final beat of the current request |
| wr_mask | output | DATA_W/8 | Byte suppress mask (1 = not written) |
| wr_rdy | input | 1 | Controller accepts the write beat this cycle |
| rd_valid | input | 1 | Read beat valid |
| rd_data | input | DATA_W | Read beat data |
| rd_last | input | 1 | Final read beat of a request |
| ref_trig | input | 1 | User pulse asking for a refresh |
| ref_req | output | 1 | One-cycle refresh request |
| ref_ack | input | 1 | Refresh request taken |
| zq_trig | input | 1 | User pulse asking for impedance calibration |
| zq_req | output | 1 | One-cycle calibration request |
| zq_ack | input | 1 | Calibration request taken |
| done | output | 1 | Run completed with all beats matching |
| error | output | 1 | A read beat mismatched |

## Verification
The assertions check on every cycle the protocol rules that need no knowledge of the run:
- requests stay silent before calibration;
- a refused command or write beat is held steady;
- command codes are legal;
- maintenance requests last one cycle and never repeat before an acknowledge;
- `done` is sticky;
- an error stops all traffic.

The bench scenarios are needed for everything that depends on the order and content of the run:
- the exact address sequence and beat patterns;
- the last-flag positions;
- write data running ahead of a stalled command channel;
- reads waiting for all writes;
- a corrupted read beat actually being caught.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ,
        PH_DONE,
        PH_FAIL
    } phase_e;

    localparam logic [2:0] CODE_WRITE = 3'b000;
    localparam logic [2:0] CODE_READ  = 3'b001;
endpackage

// File: rtl/mtm_pattern.sv
module mtm_pattern #(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 28
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int LANES = DATA_W / 32;

    // Each 32-bit lane mixes its own index with the word address.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data[32*g +: 32] = {8'(g), 24'h5A5A5A} ^ 32'(addr);
    end
endmodule

// File: rtl/mtm_seq.sv
module mtm_seq
    import mtm_pkg::*;
#(
    parameter int              ADDR_W      = 28,
    parameter int              NUM_REQ     = 8,
    parameter int              BURST_BEATS = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calib_done,
    input  logic              start,
    input  logic              cmd_rdy,
    input  logic              wdata_done,
    input  logic              rd_done,
    input  logic              err,
    output logic              cmd_en,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_go,
    output logic              done
);
    localparam int CNT_W = $clog2(NUM_REQ + 1);
    localparam int STEP  = 8 * BURST_BEATS;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              en;
    } seq_t;

    seq_t s_d, s_q;
    logic accept_w, last_req_w;

    assign cmd_en   = s_q.en & calib_done & ~err;
    assign cmd_code = (s_q.phase == PH_READ) ? CODE_READ : CODE_WRITE;
    assign cmd_addr = s_q.addr;
    assign wr_go    = (s_q.phase == PH_WRITE);
    assign done     = (s_q.phase == PH_DONE);

    always_comb begin
        s_d        = s_q;
        accept_w   = cmd_en & cmd_rdy;
        last_req_w = (s_q.cnt == CNT_W'(NUM_REQ - 1));

        case (s_q.phase)
            PH_IDLE: begin
                if (start && calib_done) begin
                    s_d.phase = PH_WRITE;
                    s_d.en    = 1'b1;
                    s_d.cnt   = '0;
                    s_d.addr  = BASE_ADDR;
                end
            end
            PH_WRITE, PH_READ: begin
                if (accept_w) begin
                    s_d.cnt  = s_q.cnt + CNT_W'(1);
                    s_d.addr = s_q.addr + ADDR_W'(STEP);
                    if (last_req_w) begin
                        s_d.en = 1'b0;
                    end
                end
                if (s_q.phase == PH_WRITE && !s_q.en && wdata_done) begin
                    s_d.phase = PH_READ;
                    s_d.en    = 1'b1;
                    s_d.cnt   = '0;
                    s_d.addr  = BASE_ADDR;
                end
                if (s_q.phase == PH_READ && !s_q.en && rd_done) begin
                    s_d.phase = PH_DONE;
                end
            end
            default: ;
        endcase

        if (err) begin
            s_d.phase = PH_FAIL;
            s_d.en    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, addr: '0, en: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mtm_wdata.sv
module mtm_wdata #(
    parameter int                DATA_W      = 256,
    parameter int                ADDR_W      = 28,
    parameter int                NUM_REQ     = 8,
    parameter int                BURST_BEATS = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              calib_done,
    input  logic              wr_rdy,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              all_sent
);
    localparam int TOTAL  = NUM_REQ * BURST_BEATS;
    localparam int TOT_W  = $clog2(TOTAL + 1);
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    typedef struct packed {
        logic [TOT_W-1:0]  total;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W-1:0] addr;
    } wd_t;

    wd_t s_d, s_q;

    mtm_pattern #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_pat (
        .addr (s_q.addr),
        .data (wr_data)
    );

    assign all_sent = (s_q.total == TOT_W'(TOTAL));
    assign wr_en    = go & calib_done & ~all_sent;
    assign wr_last  = (s_q.beat == BEAT_W'(BURST_BEATS - 1));

    always_comb begin
        s_d = s_q;
        if (wr_en && wr_rdy) begin
            s_d.total = s_q.total + TOT_W'(1);
            s_d.addr  = s_q.addr + ADDR_W'(8);
            s_d.beat  = wr_last ? '0 : s_q.beat + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{total: '0, beat: '0, addr: BASE_ADDR};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mtm_rdchk.sv
module mtm_rdchk #(
    parameter int                DATA_W      = 256,
    parameter int                ADDR_W      = 28,
    parameter int                NUM_REQ     = 8,
    parameter int                BURST_BEATS = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_last,
    output logic              all_back,
    output logic              err
);
    localparam int TOTAL  = NUM_REQ * BURST_BEATS;
    localparam int TOT_W  = $clog2(TOTAL + 1);
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    typedef struct packed {
        logic [TOT_W-1:0]  total;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } rc_t;

    rc_t s_d, s_q;
    logic [DATA_W-1:0] exp_w;
    logic              exp_last_w, bad_w;

    mtm_pattern #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_pat (
        .addr (s_q.addr),
        .data (exp_w)
    );

    assign all_back = (s_q.total == TOT_W'(TOTAL));
    assign err      = s_q.err;

    always_comb begin
        s_d        = s_q;
        exp_last_w = (s_q.beat == BEAT_W'(BURST_BEATS - 1));
        bad_w      = (rd_data != exp_w) || (rd_last != exp_last_w);
        if (rd_valid && !s_q.err && !all_back) begin
            if (bad_w) begin
                s_d.err = 1'b1;
            end else begin
                s_d.total = s_q.total + TOT_W'(1);
                s_d.addr  = s_q.addr + ADDR_W'(8);
                s_d.beat  = exp_last_w ? '0 : s_q.beat + BEAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{total: '0, beat: '0, addr: BASE_ADDR, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mtm_maint.sv
module mtm_maint (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trig,
    input  logic ack,
    output logic req
);
    typedef struct packed {
        logic req;
        logic waiting;
    } mt_t;

    mt_t s_d, s_q;

    assign req = s_q.req;

    always_comb begin
        s_d.req     = trig & enable & ~s_q.req & ~s_q.waiting;
        s_d.waiting = (s_q.req | s_q.waiting) & ~ack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{req: 1'b0, waiting: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mem_traffic_master.sv
module mem_traffic_master #(
    parameter int                DATA_W      = 256,
    parameter int                ADDR_W      = 28,
    parameter int                NUM_REQ     = 8,
    parameter int                BURST_BEATS = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
    localparam int               MASK_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calib_done,
    input  logic              start,
    output logic              cmd_en,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_rdy,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic [MASK_W-1:0] wr_mask,
    input  logic              wr_rdy,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_last,
    input  logic              ref_trig,
    output logic              ref_req,
    input  logic              ref_ack,
    input  logic              zq_trig,
    output logic              zq_req,
    input  logic              zq_ack,
    output logic              done,
    output logic              error
);
    logic wr_go_w, wdata_done_w, rd_done_w, err_w;

    assign wr_mask = '0;
    assign error   = err_w;

    mtm_seq #(
        .ADDR_W(ADDR_W), .NUM_REQ(NUM_REQ),
        .BURST_BEATS(BURST_BEATS), .BASE_ADDR(BASE_ADDR)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .calib_done (calib_done),
        .start      (start),
        .cmd_rdy    (cmd_rdy),
        .wdata_done (wdata_done_w),
        .rd_done    (rd_done_w),
        .err        (err_w),
        .cmd_en     (cmd_en),
        .cmd_code   (cmd_code),
        .cmd_addr   (cmd_addr),
        .wr_go      (wr_go_w),
        .done       (done)
    );

    mtm_wdata #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REQ(NUM_REQ),
        .BURST_BEATS(BURST_BEATS), .BASE_ADDR(BASE_ADDR)
    ) i_wdata (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (wr_go_w),
        .calib_done (calib_done),
        .wr_rdy     (wr_rdy),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_last    (wr_last),
        .all_sent   (wdata_done_w)
    );

    mtm_rdchk #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REQ(NUM_REQ),
        .BURST_BEATS(BURST_BEATS), .BASE_ADDR(BASE_ADDR)
    ) i_rdchk (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_last  (rd_last),
        .all_back (rd_done_w),
        .err      (err_w)
    );

    mtm_maint i_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (calib_done),
        .trig   (ref_trig),
        .ack    (ref_ack),
        .req    (ref_req)
    );

    mtm_maint i_zq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (calib_done),
        .trig   (zq_trig),
        .ack    (zq_ack),
        .req    (zq_req)
    );
endmodule

// File: rtl/mtm_checker.sv
module mtm_checker #(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              calib_done,
    input logic              cmd_en,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_rdy,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_last,
    input logic              wr_rdy,
    input logic              ref_req,
    input logic              ref_ack,
    input logic              zq_req,
    input logic              zq_ack,
    input logic              done,
    input logic              error
);
    logic ref_wait_q, zq_wait_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_wait_q <= 1'b0;
            zq_wait_q  <= 1'b0;
        end else begin
            ref_wait_q <= (ref_wait_q | ref_req) & ~ref_ack;
            zq_wait_q  <= (zq_wait_q | zq_req) & ~zq_ack;
        end
    end

    AST_SILENT_BEFORE_CALIB: assert property (@(posedge clk) disable iff (!rst_n)
        !calib_done |-> (!cmd_en && !wr_en)); // R1

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && !cmd_rdy) |=> (error || !calib_done ||
            (cmd_en && $stable(cmd_addr) && $stable(cmd_code)))); // R2

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |-> (cmd_code == 3'b000 || cmd_code == 3'b001)); // R3

    AST_WBEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_rdy) |=> (!calib_done ||
            (wr_en && $stable(wr_data) && $stable(wr_last)))); // R4

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!cmd_en && !wr_en && !done)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R7

    AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |=> !ref_req); // R8

    AST_ZQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        zq_req |=> !zq_req); // R8

    AST_REF_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !ref_wait_q); // R8

    AST_ZQ_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        zq_req |-> !zq_wait_q); // R8
endmodule

bind mem_traffic_master mtm_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_mem_traffic_master.sv
module test_mem_traffic_master;
    localparam int DW = 256;
    localparam int AW = 28;
    localparam int NR = 8;
    localparam int BB = 2;
    localparam int TOT = NR * BB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic calib_done = 1'b0, start = 1'b0;
    logic cmd_en, cmd_rdy = 1'b0;
    logic [2:0] cmd_code;
    logic [AW-1:0] cmd_addr;
    logic wr_en, wr_last, wr_rdy = 1'b0;
    logic [DW-1:0] wr_data;
    logic [DW/8-1:0] wr_mask;
    logic rd_valid = 1'b0, rd_last = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic ref_trig = 1'b0, ref_ack = 1'b0, zq_trig = 1'b0, zq_ack = 1'b0;
    logic ref_req, zq_req, done, error;

    always #5 clk = ~clk;

    mem_traffic_master #(.DATA_W(DW), .ADDR_W(AW), .NUM_REQ(NR), .BURST_BEATS(BB))
    i_mem_traffic_master (.*);

    int n_cmp = 0, n_bad = 0;
    int cmd_pct = 100, wr_pct = 100;
    bit corrupt_en = 0;
    int corrupt_idx = 0;

    // controller model state
    int cmds_seen, wb, rb;
    int rq[$];
    logic [DW-1:0] mem [TOT];
    bit prev_cmd_pend, prev_wr_pend;
    logic [AW-1:0] prev_addr;
    logic [2:0] prev_code;
    logic [DW-1:0] prev_wdata;
    logic prev_wlast;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        logic [DW-1:0] r;
        for (int i = 0; i < DW/32; i++) r[32*i +: 32] = {8'(i), 24'h5A5A5A} ^ {4'h0, a};
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Controller model: decisions at the falling edge apply to the next rising edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            cmds_seen = 0; wb = 0; rb = 0; rq.delete();
            prev_cmd_pend = 0; prev_wr_pend = 0;
            rd_valid = 0; rd_last = 0;
        end else begin
            if (prev_cmd_pend && !error)
                check(cmd_en && cmd_addr == prev_addr && cmd_code == prev_code,
                      "R2 refused command held", {cmd_en, cmd_code, cmd_addr}, {1'b1, prev_code, prev_addr});
            if (prev_wr_pend)
                check(wr_en && wr_data == prev_wdata && wr_last == prev_wlast,
                      "R4 refused beat held", wr_data, prev_wdata);

            cmd_rdy = ($urandom % 100) < cmd_pct;
            wr_rdy  = ($urandom % 100) < wr_pct;

            // read return first (one cycle behind acceptance at least)
            rd_valid = 0;
            if (rq.size() > 0 && ($urandom % 4) != 0) begin
                automatic int a = rq.pop_front();
                automatic logic [DW-1:0] d = mem[a/8];
                if (corrupt_en && rb == corrupt_idx) d[5] = ~d[5];
                rd_data  = d;
                rd_last  = (rb % BB) == BB - 1;
                rd_valid = 1;
                rb++;
            end

            if (cmd_en && cmd_rdy) begin
                if (cmds_seen < NR) begin
                    check(cmd_code == 3'b000 && cmd_addr == AW'(8*BB*cmds_seen), "R3 write command",
                          {cmd_code, cmd_addr}, {3'b000, AW'(8*BB*cmds_seen)});
                end else begin
                    check(cmd_code == 3'b001 && cmd_addr == AW'(8*BB*(cmds_seen-NR)), "R3 read command",
                          {cmd_code, cmd_addr}, {3'b001, AW'(8*BB*(cmds_seen-NR))});
                    if (cmds_seen == NR)
                        check(wb == TOT, "R5 reads wait for write beats", wb, TOT);
                    for (int k = 0; k < BB; k++) rq.push_back(int'(cmd_addr) + 8*k);
                end
                cmds_seen++;
            end

            if (wr_en && wr_rdy) begin
                check(wr_data == pat(AW'(8*wb)), "R4 write pattern", wr_data, pat(AW'(8*wb)));
                check(wr_last == ((wb % BB) == BB - 1), "R4 write last flag", wr_last, (wb % BB) == BB - 1);
                check(wr_mask == '0, "R4 mask all clear", wr_mask, 0);
                if (wb < TOT) mem[wb] = wr_data;
                wb++;
            end

            prev_cmd_pend = cmd_en && !cmd_rdy;
            prev_addr = cmd_addr; prev_code = cmd_code;
            prev_wr_pend = wr_en && !wr_rdy;
            prev_wdata = wr_data; prev_wlast = wr_last;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        bit quiet;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!cmd_en && !wr_en && !done && !error && !ref_req && !zq_req, "R1 reset state",
              {cmd_en, wr_en, done, error, ref_req, zq_req}, 0);

        // start without calibration
        start = 1; ref_trig = 1;
        @(negedge clk); ref_trig = 0;
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            if (cmd_en || wr_en || ref_req) quiet = 0;
            @(negedge clk);
        end
        check(quiet, "R1 silent before calibration", quiet, 1);
        check(!ref_req, "R8 trigger ignored before calibration", ref_req, 0);

        // write data with command channel stalled
        cmd_pct = 0; wr_pct = 100;
        calib_done = 1;
        repeat (TOT + 6) @(negedge clk);
        start = 0;
        check(wb == TOT, "R5 write beats ahead of commands", wb, TOT);
        check(cmds_seen == 0, "R5 no command while stalled", cmds_seen, 0);

        // maintenance during traffic
        cmd_pct = 50; wr_pct = 60;
        ref_trig = 1; @(negedge clk); ref_trig = 0;
        check(ref_req, "R8 refresh request pulse", ref_req, 1);
        @(negedge clk);
        check(!ref_req, "R8 refresh one cycle", ref_req, 0);
        ref_trig = 1; @(negedge clk); ref_trig = 0;
        check(!ref_req, "R8 retrigger ignored before ack", ref_req, 0);
        ref_ack = 1; @(negedge clk); ref_ack = 0;
        ref_trig = 1; @(negedge clk); ref_trig = 0;
        check(ref_req, "R8 refresh after ack", ref_req, 1);
        zq_trig = 1; @(negedge clk); zq_trig = 0;
        check(zq_req, "R8 calibration request pulse", zq_req, 1);
        zq_ack = 1; @(negedge clk); zq_ack = 0;
        check(!zq_req, "R8 calibration one cycle", zq_req, 0);

        for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
        check(done && !error, "R7 done after full run", {done, error}, 2'b10);
        check(cmds_seen == 2*NR && rb == TOT, "R7 all traffic seen", cmds_seen, 2*NR);
        repeat (5) @(negedge clk);
        check(done && !cmd_en && !wr_en, "R7 done sticky, idle", {done, cmd_en, wr_en}, 3'b100);

        // run with a corrupted read beat
        rst_n = 0; corrupt_en = 1; corrupt_idx = 5;
        repeat (3) @(negedge clk);
        rst_n = 1; start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 4000 && !error; i++) @(negedge clk);
        check(error && !done, "R6 mismatch flagged", {error, done}, 2'b10);
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            if (cmd_en || wr_en || done || !error) quiet = 0;
            @(negedge clk);
        end
        check(quiet, "R6 traffic stopped after error", quiet, 1);
        finish_run();
    end
endmodule